// File: doc/BRIEF.md
# Stereo Automatic Mute Detector

This block watches the stereo sample stream at the output of a serial audio receiver and mutes both channels when the input has gone idle. Once per frame a strobe presents one left word and one right word. A word is idle when every bit in it is equal, so the word is either all zeros or all ones. The block counts consecutive frames in which both words are idle. When that count reaches a run length that is set by a parameter, the automatic mute turns on. The first frame that carries any other data turns it off again.

An active-low enable input controls the automatic function. Each channel also has its own active-low manual mute input. A channel's mute output is the OR of the automatic mute and that channel's manual mute. The manual mute acts in the same cycle and has no effect on the run count. A downstream stage uses the mute outputs to silence the outputs. Ramping and analog control are not part of this block.

Top module: `stereo_auto_mute`

## Requirements
- R1: With `auto_en_ni` low, `auto_mute_o` goes high in the cycle after the strobe of the RUN_LEN-th consecutive qualifying frame (RUN_LEN defaults to 8192). It stays low through frame RUN_LEN-1.
- R2: A frame qualifies only if, at the strobe, the left word and the right word are each either all zeros or all ones. The two words need not match: a left word of zeros with a right word of ones qualifies.
- R3: A strobed frame in which either word has mixed bits clears the run. `auto_mute_o` falls in the cycle after that strobe, and a fresh run of RUN_LEN qualifying frames is needed to mute again.
- R4: While `auto_en_ni` is high, `auto_mute_o` is low and the run is held cleared. After the enable returns low, a full run of RUN_LEN frames is needed.
- R5: A low level on `mute_left_ni` or `mute_right_ni` drives that channel's mute output high in the same cycle. It has no effect on the other channel or on the run count.
- R6: `mute_left_o` equals `auto_mute_o` OR NOT `mute_left_ni`, and `mute_right_o` equals `auto_mute_o` OR NOT `mute_right_ni`.
- R7: The run count saturates at RUN_LEN. Any number of further qualifying frames keeps the mute on, and the count never wraps.
- R8: Cycles in which `frame_valid_i` is low neither advance nor clear the run, whatever the words hold.
- R9: While `rst_ni` is low, the run is cleared and `auto_mute_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | One-cycle strobe marking a new stereo frame |
| left_word_i | input | DATA_W | Left channel sample word |
| right_word_i | input | DATA_W | Right channel sample word |
| auto_en_ni | input | 1 | Automatic mute enable, active low |
| mute_left_ni | input | 1 | Manual left mute, active low |
| mute_right_ni | input | 1 | Manual right mute, active low |
| auto_mute_o | output | 1 | Automatic mute state |
| mute_left_o | output | 1 | Left channel mute, high when muted |
| mute_right_o | output | 1 | Right channel mute, high when muted |

## Verification
The run detector is driven with the following input patterns:

- **Zero-only runs and mixed runs.** Runs of all-zero frames and runs that pair zeros on one channel with ones on the other show that the idle test is applied to each word on its own.
- **Single broken frame.** A run one frame short of the threshold, followed by one frame with mixed bits, separates a correct clear from an off-by-one count.
- **Long runs.** Runs well past the threshold reveal a counter that wraps.
- **Unstrobed noise.** Mixed-bit words presented without a strobe show that data outside a frame has no effect.
- **Random streams.** Streams with random strobes, enable and manual mutes, biased toward idle words, exercise how the automatic and manual paths combine.

// File: rtl/stereo_mute_pkg.sv
package stereo_mute_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_L   = 0;
  localparam int CH_R   = 1;
  typedef logic [NUM_CH-1:0] ch_mask_t;
endpackage

// File: rtl/word_static_det.sv
module word_static_det #(
  parameter int DATA_W = 20
) (
  input  logic [DATA_W-1:0] word_i,
  output logic              static_o
);
  // idle word: every bit identical
  always_comb static_o = (&word_i) | ~(|word_i);
endmodule

// File: rtl/idle_run_tracker.sv
module idle_run_tracker #(
  parameter int RUN_LEN = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic strobe_i,
  input  logic qual_i,
  output logic reached_o
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                 cnt_d = '0;
    else if (strobe_i) begin
      if (!qual_i)             cnt_d = '0;
      else if (cnt_q != RUN_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_comb reached_o = (cnt_q == RUN_MAX);
endmodule

// File: rtl/mute_merge.sv
module mute_merge (
  input  logic auto_mute_i,
  input  logic manual_mute_ni,
  output logic mute_o
);
  always_comb mute_o = auto_mute_i | ~manual_mute_ni;
endmodule

// File: rtl/stereo_auto_mute.sv
module stereo_auto_mute #(
  parameter int DATA_W  = 20,
  parameter int RUN_LEN = 8192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_valid_i,
  input  logic [DATA_W-1:0] left_word_i,
  input  logic [DATA_W-1:0] right_word_i,
  input  logic              auto_en_ni,
  input  logic              mute_left_ni,
  input  logic              mute_right_ni,
  output logic              auto_mute_o,
  output logic              mute_left_o,
  output logic              mute_right_o
);
  import stereo_mute_pkg::*;

  logic [NUM_CH-1:0][DATA_W-1:0] words;
  ch_mask_t ch_static, manual_n, ch_mute;
  logic     run_reached;

  always_comb begin
    words[CH_L]    = left_word_i;
    words[CH_R]    = right_word_i;
    manual_n[CH_L] = mute_left_ni;
    manual_n[CH_R] = mute_right_ni;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    word_static_det #(.DATA_W(DATA_W)) u_det (
      .word_i   (words[c]),
      .static_o (ch_static[c])
    );
    mute_merge u_merge (
      .auto_mute_i    (auto_mute_o),
      .manual_mute_ni (manual_n[c]),
      .mute_o         (ch_mute[c])
    );
  end

  idle_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (auto_en_ni),
    .strobe_i  (frame_valid_i),
    .qual_i    (&ch_static),
    .reached_o (run_reached)
  );

  always_comb begin
    auto_mute_o  = run_reached & ~auto_en_ni;
    mute_left_o  = ch_mute[CH_L];
    mute_right_o = ch_mute[CH_R];
  end
endmodule

// File: rtl/stereo_auto_mute_chk.sv
module stereo_auto_mute_chk #(
  parameter int DATA_W  = 20,
  parameter int RUN_LEN = 8192
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_valid_i,
  input logic [DATA_W-1:0] left_word_i,
  input logic [DATA_W-1:0] right_word_i,
  input logic              auto_en_ni,
  input logic              mute_left_ni,
  input logic              mute_right_ni,
  input logic              auto_mute_o,
  input logic              mute_left_o,
  input logic              mute_right_o
);
  logic l_idle, r_idle;
  always_comb begin
    l_idle = (left_word_i == '0) || (left_word_i == '1);
    r_idle = (right_word_i == '0) || (right_word_i == '1);
  end

  assert_mute_needs_idle_frame_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(auto_mute_o) |-> $past(frame_valid_i && l_idle && r_idle && !auto_en_ni));

  assert_busy_frame_releases_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !(l_idle && r_idle)) |=> !auto_mute_o);

  assert_disabled_no_mute_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_en_ni |-> !auto_mute_o);

  assert_manual_left_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mute_left_ni |-> mute_left_o);

  assert_manual_right_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mute_right_ni |-> mute_right_o);

  assert_outputs_follow_auto_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_left_ni && mute_right_ni) |-> (mute_left_o == auto_mute_o && mute_right_o == auto_mute_o));

  assert_saturated_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_mute_o && frame_valid_i && l_idle && r_idle) |=> (auto_mute_o || auto_en_ni));

  assert_no_strobe_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_mute_o && !frame_valid_i) |=> (auto_mute_o || auto_en_ni));
endmodule

bind stereo_auto_mute stereo_auto_mute_chk #(.DATA_W(DATA_W), .RUN_LEN(RUN_LEN)) u_chk (.*);

// File: tb/stereo_auto_mute_test.sv
module stereo_auto_mute_test;
  localparam int DATA_W  = 20;
  localparam int RUN_LEN = 8192;
  localparam logic [DATA_W-1:0] ZW = '0;
  localparam logic [DATA_W-1:0] OW = '1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_valid_i = 1'b0;
  logic [DATA_W-1:0] left_word_i = '0, right_word_i = '0;
  logic auto_en_ni = 1'b0, mute_left_ni = 1'b1, mute_right_ni = 1'b1;
  logic auto_mute_o, mute_left_o, mute_right_o;

  int total = 0, bad = 0, run_cnt = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  stereo_auto_mute #(.DATA_W(DATA_W), .RUN_LEN(RUN_LEN)) uut (.*);

  function automatic bit idle(input logic [DATA_W-1:0] w);
    return (w == ZW) || (w == OW);
  endfunction

  function automatic logic [DATA_W-1:0] rnd_word();
    int unsigned k = $urandom_range(0, 2);
    if (k == 0) return ZW;
    if (k == 1) return OW;
    return DATA_W'($urandom);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string req);
    logic ea;
    ea = (run_cnt == RUN_LEN) && !auto_en_ni && rst_ni;
    chk(req, auto_mute_o, ea, "auto_mute");
    chk(req, mute_left_o, ea | ~mute_left_ni, "mute_left");
    chk(req, mute_right_o, ea | ~mute_right_ni, "mute_right");
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic v, input logic [DATA_W-1:0] l, input logic [DATA_W-1:0] r,
                      input logic en_n, input logic ml_n, input logic mr_n, input string req);
    frame_valid_i = v; left_word_i = l; right_word_i = r;
    auto_en_ni = en_n; mute_left_ni = ml_n; mute_right_ni = mr_n;
    @(posedge clk_i);
    if (en_n) run_cnt = 0;
    else if (v) begin
      if (idle(l) && idle(r)) run_cnt = (run_cnt < RUN_LEN) ? run_cnt + 1 : RUN_LEN;
      else run_cnt = 0;
    end
    @(negedge clk_i);
    check_outs(req);
  endtask

  task automatic frames(input int n, input logic [DATA_W-1:0] l, input logic [DATA_W-1:0] r,
                        input string req);
    for (int i = 0; i < n; i++) step(1'b1, l, r, 1'b0, 1'b1, 1'b1, req);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    // R9 reset state
    repeat (3) @(negedge clk_i);
    frame_valid_i = 1'b1;
    check_outs("R9");
    @(negedge clk_i);
    check_outs("R9");
    rst_ni = 1'b1;
    frame_valid_i = 1'b0;
    // R1 threshold exact
    frames(RUN_LEN - 1, ZW, ZW, "R1");
    chk("R1", auto_mute_o, 1'b0, "below threshold");
    frames(1, ZW, ZW, "R1");
    chk("R1", auto_mute_o, 1'b1, "at threshold");
    // R8 unstrobed noise while muted
    for (int i = 0; i < 20; i++) step(1'b0, 20'h12345, 20'h0F0F0, 1'b0, 1'b1, 1'b1, "R8");
    chk("R8", auto_mute_o, 1'b1, "held without strobe");
    // R3 release on one busy frame
    step(1'b1, ZW, 20'h00001, 1'b0, 1'b1, 1'b1, "R3");
    chk("R3", auto_mute_o, 1'b0, "released");
    // R2 mixed idle polarity, one short of threshold then broken
    frames(RUN_LEN - 1, ZW, OW, "R2");
    step(1'b1, 20'h80000, OW, 1'b0, 1'b1, 1'b1, "R3");
    frames(RUN_LEN - 1, OW, ZW, "R3");
    chk("R3", auto_mute_o, 1'b0, "fresh run needed");
    frames(1, OW, ZW, "R2");
    chk("R2", auto_mute_o, 1'b1, "mixed polarity mutes");
    // R7 saturation
    frames(2 * RUN_LEN + 5, OW, OW, "R7");
    chk("R7", auto_mute_o, 1'b1, "no wrap");
    // R5/R6 manual mutes while auto on, then auto off
    step(1'b0, ZW, ZW, 1'b0, 1'b0, 1'b1, "R5");
    step(1'b0, ZW, ZW, 1'b0, 1'b1, 1'b0, "R5");
    // R4 disable clears
    step(1'b1, ZW, ZW, 1'b1, 1'b1, 1'b1, "R4");
    chk("R4", auto_mute_o, 1'b0, "disabled");
    step(1'b0, ZW, ZW, 1'b1, 1'b0, 1'b1, "R6");
    step(1'b0, ZW, ZW, 1'b1, 1'b1, 1'b0, "R6");
    frames(RUN_LEN - 1, ZW, ZW, "R4");
    chk("R4", auto_mute_o, 1'b0, "run restarted after disable");
    frames(1, ZW, ZW, "R4");
    // random mix
    for (int i = 0; i < 20000; i++)
      step($urandom_range(0, 3) != 0, rnd_word(), rnd_word(), $urandom_range(0, 99) == 0,
           $urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0, "R6");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule